// File: doc/BRIEF.md
# Reference Clock Failover Sequencer

This block supervises a phase-locked loop that can draw its reference from either of two inputs. When the reference in use is flagged as lost, or when software pulses a manual request, the block runs a fixed recovery order. It first gates every downstream clock enable and freezes the phase detector, so the oscillator holds its last frequency. It then moves the input select to the other reference and holds the loop's reset for a minimum time. After that it re-arms the phase detector and waits for the lock indication to stay high for a programmable run of cycles. Only then does it open the output clock enables again.

The controller runs on its own free-running clock, which does not depend on any loop output. The per-input loss flags and the lock indication are asynchronous, so each passes through a two-stage synchronizer before any decision uses it. A synchronous active-high reset puts the block back into its running state, with the primary input selected. The phase detector is then enabled, the loop reset is released and all clock enables are open.

Top module: `clksw_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `refSel`=0 (primary), `pfdEn`=1, `pllReset`=0 and all `outClkEn` bits 1. This also holds when the reset arrives in the middle of a recovery sequence.
- R2: Bit 0 of `clkBadIn` flags the primary input and bit 1 flags the secondary input. Let E0 be the first edge that samples the flag of the selected input high while the block is idle. After edge E0+3, `pfdEn` is 0 and every `outClkEn` bit is 0, and `refSel` is still unchanged.
- R3: One edge after the outputs are gated, `refSel` moves to the other input (0 = primary, 1 = secondary) and `pllReset` rises on the same edge.
- R4: `pllReset` stays high for exactly RST_CYC = ceil(RST_MIN_PS / CLK_PERIOD_PS) cycles (at least 1). It falls on the same edge that sets `pfdEn` back to 1.
- R5: All `outClkEn` bits stay 0 while `pllReset` is high and during the whole relock wait.
- R6: Lock counts as stable once the synchronized lock has been high for LOCK_STABLE_CYC consecutive cycles, and any low cycle restarts the count. Let Ea be the first edge that samples `lockIn` high in its final run. The enables open after edge Ea+LOCK_STABLE_CYC+2.
- R7: A one-cycle `manualReq` pulse while idle starts the same sequence. The edge that samples it enters the freeze, and the outputs are gated one edge later.
- R8: A `manualReq` pulse during a sequence in progress has no effect on select, reset, enables or their timing.
- R9: A loss flag on the input that is not selected has no effect while idle.
- R10: A loss flag on the selected input during the relock wait returns the block to the freeze. The outputs are gated again, the select moves back to the other input and a new reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| clkBadIn | input | 2 | Asynchronous loss flags, bit 0 primary, bit 1 secondary |
| manualReq | input | 1 | Single-cycle request to switch to the other input |
| lockIn | input | 1 | Asynchronous loop lock indication |
| refSel | output | 1 | Reference select, 0 primary, 1 secondary |
| pfdEn | output | 1 | Phase detector enable, low freezes the oscillator frequency |
| pllReset | output | 1 | Loop reset |
| outClkEn | output | NUM_OUT | Per-output clock network enables |

## Verification
Some properties are checked on every cycle. The clock enables must be closed while the loop reset is high. The reset pulse must reach its minimum width. The select may only move while the phase detector is frozen and the enables are closed, and it must start a reset pulse when it moves. The enables may open only after the lock run counter is full, with the phase detector already running. A manual pulse during the relock wait must not change the state, and a loss flag on the selected input during that wait must force the freeze. Other behaviour needs the bench's scenarios, which check exact cycle positions. These cover the synchronizer latency, the one-edge-faster manual path, the restart of the lock count after a one-cycle drop, a loss flag on the unselected input being ignored, the ping-pong back to the first input, and a reset in the middle of a sequence.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FREEZE    = 3'd1,
    ST_SWITCH    = 3'd2,
    ST_RESET     = 3'd3,
    ST_WAIT_LOCK = 3'd4,
    ST_ENABLE    = 3'd5
  } swState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic gate;      // close enables, freeze phase detector
    logic swap;      // move select to the other input
    logic startRst;  // raise loop reset, load width counter
    logic tickRst;   // count down reset width
    logic relPll;    // drop loop reset, re-arm phase detector
    logic clrLock;   // clear lock run counter
    logic tickLock;  // advance lock run counter
    logic ungate;    // open enables
  } swStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    int q;
    q = (num + den - 1) / den;
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      manualReq,
  input  logic      badActive,
  input  logic      rstDone,
  input  logic      lockStable,
  output swStrobe_t strb
);
  swState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (badActive || manualReq) nextState = ST_FREEZE;
      end
      ST_FREEZE: begin
        strb.gate = 1'b1;
        nextState = ST_SWITCH;
      end
      ST_SWITCH: begin
        strb.swap     = 1'b1;
        strb.startRst = 1'b1;
        nextState     = ST_RESET;
      end
      ST_RESET: begin
        strb.tickRst = 1'b1;
        if (rstDone) begin
          strb.relPll  = 1'b1;
          strb.clrLock = 1'b1;
          nextState    = ST_WAIT_LOCK;
        end
      end
      ST_WAIT_LOCK: begin
        if (badActive) begin
          nextState = ST_FREEZE;
        end else if (lockStable) begin
          strb.ungate = 1'b1;
          nextState   = ST_ENABLE;
        end else begin
          strb.tickLock = 1'b1;
        end
      end
      ST_ENABLE: begin
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R8: a manual pulse while waiting for lock does not disturb the wait
  assert_manual_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_LOCK && manualReq && !badActive && !lockStable) |=> state == ST_WAIT_LOCK)
    else $error("manual request disturbed relock wait");

  // R10: loss of the selected input during relock forces a new freeze
  assert_rewait_bad_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_LOCK && badActive) |=> state == ST_FREEZE)
    else $error("loss during relock did not re-freeze");

endmodule

// File: rtl/clksw_datapath.sv
`timescale 1ns/1ps
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int NUM_OUT  = 4,
  parameter int RST_CYC  = 1,
  parameter int LOCK_CYC = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  swStrobe_t          strb,
  input  logic [1:0]         badSync,
  input  logic               lockSync,
  output logic               refSel,
  output logic               pfdEn,
  output logic               pllReset,
  output logic [NUM_OUT-1:0] outClkEn,
  output logic               badActive,
  output logic               rstDone,
  output logic               lockStable
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYC);
  localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_CYC);

  logic               selReg, pfdReg, pllRstReg;
  logic [NUM_OUT-1:0] clkEnReg;
  logic [RW-1:0]      rstCnt;
  logic [LW-1:0]      lockCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg    <= 1'b0;
      pfdReg    <= 1'b1;
      pllRstReg <= 1'b0;
      clkEnReg  <= '1;
    end else begin
      if (strb.swap)     selReg    <= ~selReg;
      if (strb.gate)     pfdReg    <= 1'b0;
      else if (strb.relPll) pfdReg <= 1'b1;
      if (strb.startRst) pllRstReg <= 1'b1;
      else if (strb.relPll) pllRstReg <= 1'b0;
      if (strb.gate)     clkEnReg  <= '0;
      else if (strb.ungate) clkEnReg <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstCnt <= '0;
    end else if (strb.startRst) begin
      rstCnt <= RST_LOAD;
    end else if (strb.tickRst && rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clrLock) begin
      lockCnt <= '0;
    end else if (strb.tickLock) begin
      if (!lockSync)              lockCnt <= '0;
      else if (lockCnt != LOCK_MAX) lockCnt <= lockCnt + 1'b1;
    end
  end

  assign badActive  = badSync[selReg];
  assign rstDone    = (rstCnt == RW'(1));
  assign lockStable = (lockCnt == LOCK_MAX);

  assign refSel   = selReg;
  assign pfdEn    = pfdReg;
  assign pllReset = pllRstReg;
  assign outClkEn = clkEnReg;

  // checker counters: observed run lengths
  logic [RW-1:0] rstRun;
  logic [LW-1:0] lockRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      rstRun  <= '0;
      lockRun <= '0;
    end else begin
      if (!pllRstReg)             rstRun <= '0;
      else if (rstRun != RST_LOAD) rstRun <= rstRun + 1'b1;
      if (!lockSync)               lockRun <= '0;
      else if (lockRun != LOCK_MAX) lockRun <= lockRun + 1'b1;
    end
  end

  // R2: select moves only while frozen and gated
  assert_swap_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(selReg) && !$past(rst)) |-> (!pfdReg && clkEnReg == '0))
    else $error("select moved while not frozen");

  // R3: moving the select starts a loop reset
  assert_swap_resets_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(selReg) && !$past(rst)) |-> pllRstReg)
    else $error("select moved without loop reset");

  // R4: loop reset reaches its minimum width
  assert_rst_min_width_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(pllRstReg) && !$past(rst)) |-> (rstRun == RST_LOAD && pfdReg))
    else $error("loop reset too short");

  // R5: enables closed while loop reset is high
  assert_gated_in_reset_R5: assert property (@(posedge clk) disable iff (rst)
    pllRstReg |-> clkEnReg == '0)
    else $error("enable open during loop reset");

  // R6: enables open only after a full stable lock run, detector running
  assert_ungate_stable_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkEnReg[0]) && !$past(rst)) |-> (lockRun == LOCK_MAX && pfdReg))
    else $error("enables opened without stable lock");

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int NUM_OUT         = 4,
  parameter int CLK_PERIOD_PS   = 10000,
  parameter int RST_MIN_PS      = 10000,
  parameter int LOCK_STABLE_CYC = 1024,
  parameter int SYNC_STAGES     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         clkBadIn,
  input  logic               manualReq,
  input  logic               lockIn,
  output logic               refSel,
  output logic               pfdEn,
  output logic               pllReset,
  output logic [NUM_OUT-1:0] outClkEn
);
  localparam int RST_CYC = ceilDiv(RST_MIN_PS, CLK_PERIOD_PS);

  logic [2:0] syncOut;
  logic [1:0] badSync;
  logic       lockSync;
  logic       badActive, rstDone, lockStable;
  swStrobe_t  strb;

  clksw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({lockIn, clkBadIn}),
    .dout (syncOut)
  );

  assign badSync  = syncOut[1:0];
  assign lockSync = syncOut[2];

  clksw_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .manualReq  (manualReq),
    .badActive  (badActive),
    .rstDone    (rstDone),
    .lockStable (lockStable),
    .strb       (strb)
  );

  clksw_datapath #(
    .NUM_OUT  (NUM_OUT),
    .RST_CYC  (RST_CYC),
    .LOCK_CYC (LOCK_STABLE_CYC)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .badSync    (badSync),
    .lockSync   (lockSync),
    .refSel     (refSel),
    .pfdEn      (pfdEn),
    .pllReset   (pllReset),
    .outClkEn   (outClkEn),
    .badActive  (badActive),
    .rstDone    (rstDone),
    .lockStable (lockStable)
  );
endmodule

// File: tb/clksw_tb.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  localparam int NUM_OUT = 4;
  localparam int CLK_PS  = 10000;
  localparam int RMIN_PS = 35000;
  localparam int L       = 32;
  localparam int N       = (RMIN_PS + CLK_PS - 1) / CLK_PS;  // R4 width: 4

  logic               clk = 1'b0;
  logic               rst;
  logic [1:0]         clkBadIn;
  logic               manualReq;
  logic               lockIn;
  logic               refSel, pfdEn, pllReset;
  logic [NUM_OUT-1:0] outClkEn;

  clksw_top #(
    .NUM_OUT(NUM_OUT), .CLK_PERIOD_PS(CLK_PS), .RST_MIN_PS(RMIN_PS),
    .LOCK_STABLE_CYC(L), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .clkBadIn(clkBadIn), .manualReq(manualReq),
    .lockIn(lockIn), .refSel(refSel), .pfdEn(pfdEn), .pllReset(pllReset),
    .outClkEn(outClkEn)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    int unsigned atCyc;
    logic        sel;
    logic        pfd;
    logic        prst;
    logic        en;
    int unsigned req;
  } expItem_t;

  expItem_t    expQ[$];
  int unsigned cyc = 0;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int unsigned at, input logic s, input logic p,
                      input logic r, input logic e, input int unsigned req);
    expItem_t it;
    it.atCyc = at; it.sel = s; it.pfd = p; it.prst = r; it.en = e; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: compares outputs 2 ns after each edge
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0 && expQ[0].atCyc <= cyc) begin
      expItem_t it;
      logic [NUM_OUT-1:0] enExp;
      it = expQ.pop_front();
      enExp = {NUM_OUT{it.en}};
      nChecks++;
      if (it.atCyc != cyc || refSel !== it.sel || pfdEn !== it.pfd ||
          pllReset !== it.prst || outClkEn !== enExp) begin
        nFails++;
        $display("FAIL R%0d cyc %0d: sel/pfd/rst/en actual %b/%b/%b/%b expected %b/%b/%b/%b",
                 it.req, cyc, refSel, pfdEn, pllReset, outClkEn,
                 it.sel, it.pfd, it.prst, enExp);
      end
    end
  end

  task automatic goTo(input int unsigned c);
    while (cyc < c) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    int unsigned e0, ea, ea2, f0, c;
    rst = 1'b1; clkBadIn = 2'b00; manualReq = 1'b0; lockIn = 1'b1;
    #3;
    push(5, 0, 1, 0, 1, 1);                        // R1 reset state
    goTo(4); rst = 1'b0;

    // primary lost: freeze, switch, reset, relock; manual pulse ignored
    goTo(10); e0 = 11; ea = e0 + 11;
    push(e0+2,   0, 1, 0, 1, 2);                   // R2 not yet gated
    push(e0+3,   0, 0, 0, 0, 2);                   // R2 frozen and gated
    push(e0+4,   1, 0, 1, 0, 3);                   // R3 switched, reset high
    push(e0+3+N, 1, 0, 1, 0, 4);                   // R4 reset still high
    push(e0+4+N, 1, 1, 0, 0, 4);                   // R4 released, pfd back, R5 gated
    push(ea+10,  1, 1, 0, 0, 8);                   // R8 manual pulse ignored
    push(ea+L+1, 1, 1, 0, 0, 6);                   // R6 one cycle short
    push(ea+L+2, 1, 1, 0, 1, 6);                   // R6 enables open
    clkBadIn[0] = 1'b1; lockIn = 1'b0;
    goTo(e0+10); lockIn = 1'b1;
    goTo(ea+5);  manualReq = 1'b1;
    goTo(ea+6);  manualReq = 1'b0;
    goTo(ea+L+6);

    // manual switch back to primary, lock drops once mid-count
    clkBadIn[0] = 1'b0;
    c = cyc + 5; e0 = c + 1; ea = e0 + 6; ea2 = ea + 12;
    push(e0,      1, 1, 0, 1, 7);                  // R7 state entered, outputs unchanged
    push(e0+1,    1, 0, 0, 0, 7);                  // R7 gated one edge later
    push(e0+2,    0, 0, 1, 0, 3);                  // R3 back to primary
    push(e0+1+N,  0, 0, 1, 0, 4);                  // R4
    push(e0+2+N,  0, 1, 0, 0, 4);                  // R4
    push(ea+L+2,  0, 1, 0, 0, 6);                  // R6 count restarted by drop
    push(ea2+L+1, 0, 1, 0, 0, 6);                  // R6
    push(ea2+L+2, 0, 1, 0, 1, 6);                  // R6
    goTo(c); manualReq = 1'b1; lockIn = 1'b0;
    goTo(c+1); manualReq = 1'b0;
    goTo(ea-1); lockIn = 1'b1;
    goTo(ea+10); lockIn = 1'b0;
    goTo(ea+11); lockIn = 1'b1;
    goTo(ea2+L+6);

    // loss on the unselected input while idle
    c = cyc;
    push(c+8, 0, 1, 0, 1, 9);                      // R9 no effect
    clkBadIn[1] = 1'b1;
    goTo(c+8); clkBadIn[1] = 1'b0;
    goTo(c+12);

    // loss on newly selected input during relock
    c = cyc; e0 = c + 1; f0 = e0 + 11; ea = f0 + 7 + N;
    push(e0+3,   0, 0, 0, 0, 2);                   // R2
    push(e0+4,   1, 0, 1, 0, 3);                   // R3
    push(f0+2,   1, 1, 0, 0, 10);                  // R10 still waiting
    push(f0+3,   1, 0, 0, 0, 10);                  // R10 frozen again
    push(f0+4,   0, 0, 1, 0, 10);                  // R10 switched back, reset
    push(f0+4+N, 0, 1, 0, 0, 10);                  // R10 released
    push(ea+L+1, 0, 1, 0, 0, 6);                   // R6
    push(ea+L+2, 0, 1, 0, 1, 10);                  // R10 recovered on primary
    clkBadIn = 2'b01; lockIn = 1'b0;
    goTo(e0+10); clkBadIn = 2'b10;
    goTo(ea-1); lockIn = 1'b1;
    goTo(ea+L+4); clkBadIn = 2'b00;
    goTo(cyc+6);

    // reset during a sequence
    c = cyc; e0 = c + 1;
    push(e0+5,  1, 0, 1, 0, 3);                    // R3 mid-reset
    push(e0+6,  0, 1, 0, 1, 1);                    // R1 reset mid-sequence
    push(e0+12, 0, 1, 0, 1, 1);                    // R1 stays idle
    clkBadIn[0] = 1'b1; lockIn = 1'b0;
    goTo(e0+5); rst = 1'b1; clkBadIn = 2'b00;
    goTo(e0+8); rst = 1'b0;
    goTo(e0+14); lockIn = 1'b1;

    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R1 pending checks actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule